// File: doc/BRIEF.md
# Iterative Word-Parallel CORDIC Engine

This block evaluates one CORDIC operation over several clock cycles using a single datapath. That datapath holds three full-width add/subtract units and two barrel shifters, and it is used again on every step. A strobe loads a starting vector (x, y) and an angle accumulator z, along with a coordinate-system code and a mode bit. A small controller then walks the datapath through a fixed number of micro-rotations. For each step the controller picks the shift amount from a sequence that depends on the coordinate system. It also picks that step's angle constant from a table. The table is built from the parameters when the design is elaborated.

Rotation mode drives z toward zero and turns the vector by the requested angle. Vectoring mode drives y toward zero and gathers the angle in z. The outputs are the raw pseudo-rotation results. The gain is not corrected, and no quadrant pre-rotation is applied. Data is two's complement with FRAC fractional bits, and the angle is in radians in the same format.

Top module: `cordic_iter`

## Requirements
- R1: After synchronous reset, busy and done are 0 and x_out, y_out and z_out are 0.
- R2: A start seen in the idle state captures x_in, y_in, z_in, sys_sel and vec_mode. busy is then high for exactly ITERS cycles, beginning with the following cycle.
- R3: done is high for exactly one cycle, and busy is low in that cycle. If start is high in cycle 0, done is high in cycle ITERS+1.
- R4: A start that arrives while busy is high, or in the done cycle, is ignored. It does not change the result or the timing, and no new operation begins.
- R5: Step k uses shift s and constant a, with c = +1 or -1. The step computes y' = y + c*(x>>>s) and z' = z - c*a. For the circular system (sys_sel 0) it computes x' = x - c*(y>>>s), with s = k and a = atan(2^-s). All arithmetic wraps modulo 2^16.
- R6: For the linear system (sys_sel 1), x is left unchanged. The shift is s = k+1 and the constant is a = 2^-s.
- R7: For the hyperbolic system (sys_sel 2), x' = x + c*(y>>>s) and a = atanh(2^-s). The shift starts at 1 and rises by one per step, except that shifts 4 and 13 are each used for two consecutive steps.
- R8: In rotation mode (vec_mode 0), c = -1 when z is negative and +1 otherwise. This includes the case z = 0.
- R9: In vectoring mode (vec_mode 1), c = -1 when x and y have equal sign bits and +1 otherwise.
- R10: Each constant is floor(value*2^FRAC + 0.5). A sys_sel code of 3 behaves exactly like the circular system.
- R11: x_out, y_out and z_out keep the last result until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| sys_sel | input | 2 | Coordinate system: 0 circular, 1 linear, 2 hyperbolic, 3 circular |
| vec_mode | input | 1 | 0 rotation, 1 vectoring |
| x_in | input | 16 | Initial x |
| y_in | input | 16 | Initial y |
| z_in | input | 16 | Initial angle |
| busy | output | 1 | Iterations in progress |
| done | output | 1 | One-cycle completion pulse |
| x_out | output | 16 | Resulting x |
| y_out | output | 16 | Resulting y |
| z_out | output | 16 | Resulting angle |

## Verification
Two events can meet in one cycle: a fresh start request, and a running operation that is either still iterating or finishing. The bench raises start with different operands in the load cycle and halfway through the iterations. It also raises start in the done cycle. It then requires three things: the reported result is still the bit-exact model of the first operation, done comes on exactly the expected cycle, and busy stays low after the done pulse. The hyperbolic runs pass both repeated shifts, so a skipped or extra repeat shows up as a mismatch in the final x, y and z.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

    localparam int DW = 16;

    typedef logic signed [DW-1:0] word_t;

    typedef enum logic [1:0] {
        SYS_CIRC = 2'd0,
        SYS_LIN  = 2'd1,
        SYS_HYP  = 2'd2,
        SYS_ALT  = 2'd3
    } sys_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOAD = 2'd1,
        ST_ITER = 2'd2,
        ST_DONE = 2'd3
    } state_e;

    typedef struct packed {
        word_t x;
        word_t y;
        word_t z;
    } vec_t;

    // Shift used by the first micro-rotation of each system.
    function automatic int first_shift(sys_e s);
        return (s == SYS_LIN || s == SYS_HYP) ? 1 : 0;
    endfunction

    // Hyperbolic shifts that are applied twice: 4, 13, 40, ...
    function automatic logic is_repeat(int s);
        int   r;
        logic hit;
        r   = 4;
        hit = 1'b0;
        for (int k = 0; k < 6; k++) begin
            if (r == s) hit = 1'b1;
            r = 3 * r + 1;
        end
        return hit;
    endfunction

    function automatic real pow2neg(int s);
        real t;
        t = 1.0;
        for (int k = 0; k < s; k++) t = t / 2.0;
        return t;
    endfunction

    function automatic word_t to_fix(real v, int frac);
        real sc;
        sc = 1.0;
        for (int k = 0; k < frac; k++) sc = sc * 2.0;
        return word_t'($rtoi(v * sc + 0.5));
    endfunction

    function automatic word_t atan_c(int s, int frac);
        return to_fix($atan(pow2neg(s)), frac);
    endfunction

    function automatic word_t atanh_c(int s, int frac);
        real t;
        t = pow2neg(s);
        if (s == 0) return '0;
        return to_fix(0.5 * $ln((1.0 + t) / (1.0 - t)), frac);
    endfunction

    function automatic word_t lin_c(int s, int frac);
        return to_fix(pow2neg(s), frac);
    endfunction

endpackage

// File: rtl/cordic_atan_rom.sv
module cordic_atan_rom
    import cordic_pkg::*;
#(
    parameter int ITERS = 16,
    parameter int FRAC  = 13,
    parameter int DEPTH = ITERS + 2,
    parameter int SW    = $clog2(DEPTH)
) (
    input  sys_e           sys,
    input  logic [SW-1:0]  sh,
    output word_t          alpha
);

    word_t circ_t [DEPTH];
    word_t hyp_t  [DEPTH];
    word_t lin_t  [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_tab
        assign circ_t[g] = atan_c(g, FRAC);
        assign hyp_t[g]  = atanh_c(g, FRAC);
        assign lin_t[g]  = lin_c(g, FRAC);
    end

    always_comb begin
        case (sys)
            SYS_LIN: alpha = lin_t[sh];
            SYS_HYP: alpha = hyp_t[sh];
            default: alpha = circ_t[sh];
        endcase
    end

endmodule

// File: rtl/cordic_step.sv
module cordic_step
    import cordic_pkg::*;
#(
    parameter int SW = 5
) (
    input  vec_t           cur,
    input  logic [SW-1:0]  sh,
    input  word_t          alpha,
    input  sys_e           sys,
    input  logic           neg,
    output vec_t           nxt
);

    word_t xv, yv, xs, ys;

    assign xv = cur.x;
    assign yv = cur.y;
    assign xs = xv >>> sh;
    assign ys = yv >>> sh;

    always_comb begin
        nxt.y = neg ? (cur.y - xs) : (cur.y + xs);
        nxt.z = neg ? (cur.z + alpha) : (cur.z - alpha);
        case (sys)
            SYS_LIN: nxt.x = cur.x;
            SYS_HYP: nxt.x = neg ? (cur.x - ys) : (cur.x + ys);
            default: nxt.x = neg ? (cur.x + ys) : (cur.x - ys);
        endcase
    end

endmodule

// File: rtl/cordic_ctrl.sv
module cordic_ctrl
    import cordic_pkg::*;
#(
    parameter int ITERS = 16,
    parameter int SW    = 5,
    parameter int IW    = (ITERS > 1) ? $clog2(ITERS) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  sys_e           sys_in,
    output logic           busy,
    output logic           done,
    output logic           load_en,
    output logic           step_en,
    output logic [SW-1:0]  sh
);

    localparam logic [IW-1:0] LAST = IW'(ITERS - 1);

    state_e          st;
    logic [IW-1:0]   iter;
    logic            rep;
    logic            hyp;

    assign load_en = (st == ST_IDLE) && start;
    assign step_en = (st == ST_LOAD) || (st == ST_ITER);
    assign busy    = step_en;
    assign done    = (st == ST_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= ST_IDLE;
            iter <= '0;
            sh   <= '0;
            rep  <= 1'b0;
            hyp  <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        st   <= ST_LOAD;
                        iter <= '0;
                        sh   <= SW'(first_shift(sys_in));
                        rep  <= 1'b0;
                        hyp  <= (sys_in == SYS_HYP);
                    end
                end
                ST_LOAD, ST_ITER: begin
                    iter <= iter + 1'b1;
                    if (hyp && is_repeat(int'(sh)) && !rep) begin
                        rep <= 1'b1;
                    end else begin
                        sh  <= sh + 1'b1;
                        rep <= 1'b0;
                    end
                    st <= (iter == LAST) ? ST_DONE : ST_ITER;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R2
    iter_count_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ITER) |-> (iter == $past(iter) + 1'b1));

    // R7
    shift_step_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_ITER) |-> (sh == $past(sh) || sh == $past(sh) + 1'b1));

    // R7
    hyp_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && hyp) |-> (sh != '0));

endmodule

// File: rtl/cordic_iter.sv
module cordic_iter
    import cordic_pkg::*;
#(
    parameter int ITERS = 16,
    parameter int FRAC  = 13,
    parameter int DEPTH = ITERS + 2,
    parameter int SW    = $clog2(DEPTH)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [1:0]           sys_sel,
    input  logic                 vec_mode,
    input  logic signed [DW-1:0] x_in,
    input  logic signed [DW-1:0] y_in,
    input  logic signed [DW-1:0] z_in,
    output logic                 busy,
    output logic                 done,
    output logic signed [DW-1:0] x_out,
    output logic signed [DW-1:0] y_out,
    output logic signed [DW-1:0] z_out
);

    vec_t           cur_q, nxt;
    sys_e           sys_q;
    logic           mode_q;
    logic           load_en, step_en, neg;
    logic [SW-1:0]  sh;
    word_t          alpha;

    cordic_ctrl #(.ITERS(ITERS), .SW(SW)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .sys_in  (sys_e'(sys_sel)),
        .busy    (busy),
        .done    (done),
        .load_en (load_en),
        .step_en (step_en),
        .sh      (sh)
    );

    cordic_atan_rom #(.ITERS(ITERS), .FRAC(FRAC), .DEPTH(DEPTH), .SW(SW)) u_rom (
        .sys   (sys_q),
        .sh    (sh),
        .alpha (alpha)
    );

    // Direction: rotation follows sign of z, vectoring opposes sign of x*y.
    assign neg = mode_q ? (cur_q.x[DW-1] == cur_q.y[DW-1]) : cur_q.z[DW-1];

    cordic_step #(.SW(SW)) u_step (
        .cur   (cur_q),
        .sh    (sh),
        .alpha (alpha),
        .sys   (sys_q),
        .neg   (neg),
        .nxt   (nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '0;
            sys_q  <= SYS_CIRC;
            mode_q <= 1'b0;
        end else if (load_en) begin
            cur_q  <= '{x: x_in, y: y_in, z: z_in};
            sys_q  <= sys_e'(sys_sel);
            mode_q <= vec_mode;
        end else if (step_en) begin
            cur_q  <= nxt;
        end
    end

    assign x_out = cur_q.x;
    assign y_out = cur_q.y;
    assign z_out = cur_q.z;

    // R3
    done_after_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy));

    // R11
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !load_en) |=> $stable(cur_q));

    // R4
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> (busy || done));

endmodule

// File: tb/test_cordic_iter.sv
module test_cordic_iter;

    localparam int N    = 16;
    localparam int FRAC = 13;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start = 1'b0;
    logic [1:0]         sys_sel = 2'd0;
    logic               vec_mode = 1'b0;
    logic signed [15:0] x_in = '0, y_in = '0, z_in = '0;
    logic               busy, done;
    logic signed [15:0] x_out, y_out, z_out;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    cordic_iter #(.ITERS(N), .FRAC(FRAC)) i_cordic_iter (
        .clk(clk), .rst(rst), .start(start), .sys_sel(sys_sel), .vec_mode(vec_mode),
        .x_in(x_in), .y_in(y_in), .z_in(z_in), .busy(busy), .done(done),
        .x_out(x_out), .y_out(y_out), .z_out(z_out)
    );

    task automatic chk(bit ok, string req, string what, logic [47:0] act, logic [47:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Step constant, rounded to nearest (R10).
    function automatic logic signed [15:0] bconst(int kind, int s);
        real t, v;
        t = 1.0;
        for (int k = 0; k < s; k++) t = t / 2.0;
        if (kind == 1)      v = t;
        else if (kind == 2) v = (s == 0) ? 0.0 : 0.5 * $ln((1.0 + t) / (1.0 - t));
        else                v = $atan(t);
        return 16'($rtoi(v * 8192.0 + 0.5));
    endfunction

    function automatic logic [47:0] model(int sysc, bit vm,
                                          logic signed [15:0] x0, y0, z0);
        logic signed [15:0] x, y, z, xs, ys, a;
        int kind, s;
        bit rep, neg;
        x = x0; y = y0; z = z0;
        kind = (sysc == 3) ? 0 : sysc;
        s = (kind == 0) ? 0 : 1;
        rep = 1'b0;
        for (int i = 0; i < N; i++) begin
            neg = vm ? (x[15] == y[15]) : z[15];
            xs = x >>> s;
            ys = y >>> s;
            a  = bconst(kind, s);
            if (kind == 0)      x = neg ? x + ys : x - ys;
            else if (kind == 2) x = neg ? x - ys : x + ys;
            y = neg ? y - xs : y + xs;
            z = neg ? z + a : z - a;
            if (kind == 2 && (s == 4 || s == 13) && !rep) rep = 1'b1;
            else begin s++; rep = 1'b0; end
        end
        return {x, y, z};
    endfunction

    function automatic string req_of(int sysc, bit vm);
        string r;
        case (sysc)
            1: r = "R6";
            2: r = "R7";
            3: r = "R10";
            default: r = "R5";
        endcase
        return vm ? {r, "/R9"} : {r, "/R8"};
    endfunction

    task automatic run_op(int sysc, bit vm, logic signed [15:0] x0, y0, z0,
                          bit poke_busy, bit poke_done);
        logic [47:0] exp;
        int bad;
        exp = model(sysc, vm, x0, y0, z0);
        sys_sel = 2'(sysc); vec_mode = vm;
        x_in = x0; y_in = y0; z_in = z0;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        bad = 0;
        for (int k = 1; k <= N; k++) begin
            if (!(busy === 1'b1 && done === 1'b0)) bad++;
            if (poke_busy && (k == 1 || k == N / 2)) begin
                start = 1'b1; sys_sel = 2'($urandom_range(0, 3)); vec_mode = ~vm;
                x_in = 16'($urandom); y_in = 16'($urandom); z_in = 16'($urandom);
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        chk(bad == 0, "R2", "busy window", 48'(bad), 48'd0);
        chk(done === 1'b1 && busy === 1'b0, "R3", "done timing", {46'd0, busy, done}, 48'd1);
        chk({x_out, y_out, z_out} === exp, poke_busy ? {req_of(sysc, vm), "/R4"} : req_of(sysc, vm),
            "result", {x_out, y_out, z_out}, exp);
        if (poke_done) begin
            start = 1'b1; x_in = 16'($urandom); y_in = 16'($urandom); z_in = 16'($urandom);
        end
        @(negedge clk);
        start = 1'b0;
        chk(done === 1'b0 && busy === 1'b0, "R3/R4", "after done", {46'd0, busy, done}, 48'd0);
        @(negedge clk);
        chk({x_out, y_out, z_out} === exp && busy === 1'b0, "R11", "held result",
            {x_out, y_out, z_out}, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R1", "reset flags", {46'd0, busy, done}, 48'd0);
        chk({x_out, y_out, z_out} === 48'd0, "R1", "reset outputs", {x_out, y_out, z_out}, 48'd0);

        // Directed corner cases
        run_op(0, 1'b0, 16'sd4975, 16'sd0, 16'sd6434, 1'b0, 1'b0);   // R5 R8
        run_op(0, 1'b1, 16'sd4000, 16'sd3000, 16'sd0, 1'b0, 1'b0);   // R5 R9
        run_op(0, 1'b0, 16'sd3000, -16'sd2000, 16'sd0, 1'b0, 1'b0);  // R8 z = 0 tie
        run_op(1, 1'b0, 16'sd4096, 16'sd0, 16'sd4096, 1'b0, 1'b0);   // R6
        run_op(1, 1'b1, 16'sd4096, 16'sd2048, 16'sd0, 1'b0, 1'b0);   // R6 R9
        run_op(2, 1'b0, 16'sd8192, 16'sd0, 16'sd3000, 1'b0, 1'b0);   // R7
        run_op(2, 1'b1, 16'sd8192, 16'sd4000, 16'sd0, 1'b0, 1'b0);   // R7 R9
        run_op(3, 1'b0, 16'sd4975, 16'sd0, -16'sd5000, 1'b0, 1'b0);  // R10
        run_op(0, 1'b1, -16'sd3000, -16'sd3000, 16'sd0, 1'b0, 1'b0); // R9 equal signs
        run_op(0, 1'b0, -16'sd32768, 16'sd32767, -16'sd32768, 1'b0, 1'b0); // wrap
        run_op(2, 1'b0, 16'sd9000, 16'sd1000, -16'sd2500, 1'b1, 1'b1);    // R4
        run_op(0, 1'b1, 16'sd2000, -16'sd5000, 16'sd100, 1'b1, 1'b1);     // R4

        // Constrained random operations
        for (int t = 0; t < 60; t++) begin
            int sc;
            bit vm;
            sc = $urandom_range(0, 3);
            vm = 1'($urandom);
            run_op(sc, vm,
                   16'($signed($urandom_range(0, 16000)) - 8000),
                   16'($signed($urandom_range(0, 16000)) - 8000),
                   16'($signed($urandom_range(0, 16000)) - 8000),
                   1'($urandom), 1'($urandom));
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule